// File: doc/BRIEF.md
# ICOUNT Thread Fetch Selector

This block sits at the front of a simultaneous-multithreading pipeline. Each clock it decides which one of four hardware threads may fetch. For each thread it keeps three pieces of state: an active flag, a program counter and a count of that thread's instructions now in flight between fetch and issue. Among the threads that are active and have room in their back-end partition, it grants the one with the fewest instructions in flight. This steers fetch bandwidth so that the threads hold roughly equal shares of the machine.

The grant is combinational from registered state. The granted thread's PC leaves on `fetch_pc_o` in the same cycle. On the next clock edge that PC steps forward by one fetch block, and the thread's in-flight count grows by the fetch width. Issue and flush inputs lower each count. A redirect input can load a new PC into any thread at any time. When no thread qualifies, the block reports idle and grants nothing.

Top module: `icount_fetch_sel`

## Requirements
- R1: After reset, no thread is active, every in-flight count is 0, every PC is 0, `idle_o` is 1, `fetch_vld_o` is 0 and the round-robin start position is thread 0.
- R2: A thread whose bit is set in `act_set_i` is active from the next cycle on. A thread whose bit is set in `act_clr_i` is inactive from the next cycle on. If both bits are set, clear wins. An inactive thread is never granted.
- R3: The granted thread is always one with the lowest in-flight count among the eligible threads. A thread is eligible when it is active and its count is at most 12.
- R4: When several eligible threads share that lowest count, the search starts at the round-robin position and moves upward with wrap-around. After a grant to thread g, the position becomes g+1 modulo 4. Without a grant, the position holds.
- R5: A thread whose count exceeds 12 (the partition limit of 16 minus the fetch width of 4) is never granted. The other threads still are.
- R6: When no thread is eligible, `fetch_vld_o` is 0 and `idle_o` is 1. Otherwise `fetch_vld_o` is 1 and `idle_o` is 0.
- R7: On each clock edge, a thread's count becomes its old count, plus 4 if it was granted, minus its `iss_n_i` field, minus its `flush_n_i` field, all applied together and floored at 0. Thread t's fields are `iss_n_i[3t+2:3t]` and `flush_n_i[6t+5:6t]`.
- R8: `fetch_tid_o` gives the granted thread's index in binary. `fetch_pc_o` gives that thread's current PC, and 0 when there is no grant. Unless a redirect is present, the granted PC then grows by 16 and the PCs of threads that were not granted hold.
- R9: When thread t's bit of `redir_i` is set, its PC on the next cycle is `redir_pc_i[32t+31:32t]`. This takes priority over the fetch advance, even when the thread is granted in that same cycle.
- R10: When only one thread is active and its count stays at or below 12, that thread is granted in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_set_i | input | 4 | Per-thread activate request |
| act_clr_i | input | 4 | Per-thread deactivate request (wins over set) |
| iss_n_i | input | 12 | Per-thread instructions issued this cycle, 3 bits each |
| flush_n_i | input | 24 | Per-thread instructions flushed this cycle, 6 bits each |
| redir_i | input | 4 | Per-thread PC redirect strobe |
| redir_pc_i | input | 128 | Per-thread redirect target, 32 bits each |
| fetch_vld_o | output | 1 | A thread is granted fetch this cycle |
| fetch_tid_o | output | 2 | Granted thread index |
| fetch_pc_o | output | 32 | PC the granted thread fetches from |
| idle_o | output | 1 | No thread is eligible this cycle |

## Verification
A count that drifts shows up at the ports in one of two ways: a different thread wins a later comparison, or a thread stalls at the partition limit too early or too late. So a bad count becomes visible within a few grants, not at the moment it goes wrong. A corrupted round-robin position shows on the next tie, and a wrong PC shows the next time that thread is granted. The bench therefore holds a cycle-accurate reference of all counts, PCs and the round-robin position, and compares every cycle's grant, PC and idle flag over long mixed runs, starting with single-thread runs that drive a thread right up to its limit.

// File: rtl/icf_pkg.sv
package icf_pkg;
    localparam int ICF_THREADS   = 4;
    localparam int ICF_CNT_W     = 6;
    localparam int ICF_PART_LIM  = 16;
    localparam int ICF_FETCH_N   = 4;
    localparam int ICF_INSTR_B   = 4;
    localparam int ICF_PC_W      = 32;
    localparam int ICF_ISS_W     = 3;

    // next thread index with wrap-around
    function automatic int wrap_inc(input int v, input int n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction
endpackage

// File: rtl/icf_thread.sv
module icf_thread #(
    parameter int CNT_W   = icf_pkg::ICF_CNT_W,
    parameter int PC_W    = icf_pkg::ICF_PC_W,
    parameter int ISS_W   = icf_pkg::ICF_ISS_W,
    parameter int LIM     = icf_pkg::ICF_PART_LIM,
    parameter int FETCH_N = icf_pkg::ICF_FETCH_N,
    parameter int INSTR_B = icf_pkg::ICF_INSTR_B
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic             clr_i,
    input  logic             grant_i,
    input  logic [ISS_W-1:0] iss_n_i,
    input  logic [CNT_W-1:0] flush_n_i,
    input  logic             redir_i,
    input  logic [PC_W-1:0]  redir_pc_i,
    output logic             act_o,
    output logic             elig_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [PC_W-1:0]  pc_o
);
    localparam int SW     = CNT_W + 1;
    localparam int STEP   = FETCH_N * INSTR_B;
    localparam int ROOM   = LIM - FETCH_N;

    typedef struct packed {
        logic             act;
        logic [CNT_W-1:0] cnt;
        logic [PC_W-1:0]  pc;
    } thr_st_t;

    thr_st_t st_d, st_q;
    logic [SW-1:0] sum, sub;

    always_comb begin
        st_d = st_q;
        // activation: clear has priority
        if (clr_i)      st_d.act = 1'b0;
        else if (set_i) st_d.act = 1'b1;
        // in-flight count
        sum = {1'b0, st_q.cnt} + (grant_i ? SW'(FETCH_N) : '0);
        sub = SW'(iss_n_i) + {1'b0, flush_n_i};
        st_d.cnt = (sum >= sub) ? CNT_W'(sum - sub) : '0;
        // program counter: redirect wins over advance
        if (redir_i)      st_d.pc = redir_pc_i;
        else if (grant_i) st_d.pc = st_q.pc + PC_W'(STEP);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign act_o  = st_q.act;
    assign cnt_o  = st_q.cnt;
    assign pc_o   = st_q.pc;
    assign elig_o = st_q.act && (st_q.cnt <= CNT_W'(ROOM));

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(LIM));
    // R8
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_i && !redir_i) |=> (st_q.pc == $past(st_q.pc) + PC_W'(STEP)));
    // R9
    pc_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_i |=> (st_q.pc == $past(redir_pc_i)));
    // R2
    grant_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_i |-> st_q.act);
endmodule

// File: rtl/icf_pick.sv
module icf_pick #(
    parameter int N     = icf_pkg::ICF_THREADS,
    parameter int CNT_W = icf_pkg::ICF_CNT_W,
    parameter int TID_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     elig_i,
    input  logic [CNT_W-1:0] cnt_i [N],
    input  logic [TID_W-1:0] rr_i,
    output logic             vld_o,
    output logic [TID_W-1:0] id_o
);
    logic [CNT_W-1:0] min_v;

    always_comb begin
        min_v = '1;
        for (int i = 0; i < N; i++) begin
            if (elig_i[i] && (cnt_i[i] < min_v)) min_v = cnt_i[i];
        end
        vld_o = 1'b0;
        id_o  = '0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = (int'(rr_i) + k) % N;
            if (!vld_o && elig_i[j] && (cnt_i[j] == min_v)) begin
                vld_o = 1'b1;
                id_o  = TID_W'(j);
            end
        end
    end
endmodule

// File: rtl/icount_fetch_sel.sv
module icount_fetch_sel #(
    parameter int N       = icf_pkg::ICF_THREADS,
    parameter int CNT_W   = icf_pkg::ICF_CNT_W,
    parameter int PC_W    = icf_pkg::ICF_PC_W,
    parameter int ISS_W   = icf_pkg::ICF_ISS_W,
    parameter int LIM     = icf_pkg::ICF_PART_LIM,
    parameter int FETCH_N = icf_pkg::ICF_FETCH_N,
    parameter int INSTR_B = icf_pkg::ICF_INSTR_B,
    localparam int TID_W  = (N > 1) ? $clog2(N) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N-1:0]       act_set_i,
    input  logic [N-1:0]       act_clr_i,
    input  logic [N*ISS_W-1:0] iss_n_i,
    input  logic [N*CNT_W-1:0] flush_n_i,
    input  logic [N-1:0]       redir_i,
    input  logic [N*PC_W-1:0]  redir_pc_i,
    output logic               fetch_vld_o,
    output logic [TID_W-1:0]   fetch_tid_o,
    output logic [PC_W-1:0]    fetch_pc_o,
    output logic               idle_o
);
    typedef struct packed {
        logic [TID_W-1:0] rr;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [N-1:0]     elig, act, gnt;
    logic [CNT_W-1:0] cnt_a [N];
    logic [PC_W-1:0]  pc_a  [N];
    logic             vld;
    logic [TID_W-1:0] tid;

    for (genvar t = 0; t < N; t++) begin : g_thr
        assign gnt[t] = vld && (tid == TID_W'(t));
        icf_thread #(
            .CNT_W(CNT_W), .PC_W(PC_W), .ISS_W(ISS_W),
            .LIM(LIM), .FETCH_N(FETCH_N), .INSTR_B(INSTR_B)
        ) u_thr (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_i      (act_set_i[t]),
            .clr_i      (act_clr_i[t]),
            .grant_i    (gnt[t]),
            .iss_n_i    (iss_n_i[t*ISS_W +: ISS_W]),
            .flush_n_i  (flush_n_i[t*CNT_W +: CNT_W]),
            .redir_i    (redir_i[t]),
            .redir_pc_i (redir_pc_i[t*PC_W +: PC_W]),
            .act_o      (act[t]),
            .elig_o     (elig[t]),
            .cnt_o      (cnt_a[t]),
            .pc_o       (pc_a[t])
        );
    end

    icf_pick #(.N(N), .CNT_W(CNT_W), .TID_W(TID_W)) u_pick (
        .elig_i (elig),
        .cnt_i  (cnt_a),
        .rr_i   (st_q.rr),
        .vld_o  (vld),
        .id_o   (tid)
    );

    always_comb begin
        st_d = st_q;
        if (vld) st_d.rr = TID_W'(icf_pkg::wrap_inc(int'(tid), N));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fetch_vld_o = vld;
    assign fetch_tid_o = tid;
    assign fetch_pc_o  = vld ? pc_a[tid] : '0;
    assign idle_o      = !vld;

    // R6
    idle_when_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (elig == '0) |-> (idle_o && !fetch_vld_o));
    // R6
    grant_when_some_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (elig != '0) |-> fetch_vld_o);
    // R5
    no_full_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_vld_o |-> (cnt_a[fetch_tid_o] <= CNT_W'(LIM - FETCH_N)));
    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    for (genvar t = 0; t < N; t++) begin : g_min_chk
        // R3
        lowest_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (fetch_vld_o && elig[t]) |-> (cnt_a[fetch_tid_o] <= cnt_a[t]));
    end
endmodule

// File: tb/icount_fetch_sel_bench.sv
module icount_fetch_sel_bench;
    localparam int N = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    act_set_i = '0, act_clr_i = '0, redir_i = '0;
    logic [11:0]   iss_n_i = '0;
    logic [23:0]   flush_n_i = '0;
    logic [127:0]  redir_pc_i = '0;
    logic          fetch_vld_o, idle_o;
    logic [1:0]    fetch_tid_o;
    logic [31:0]   fetch_pc_o;

    int checks = 0, errors = 0;
    bit done = 0;

    // reference state
    bit          m_act [N];
    int          m_cnt [N];
    logic [31:0] m_pc  [N];
    int          m_rr;
    bit          e_vld;
    int          e_tid;

    icount_fetch_sel u_icount_fetch_sel (
        .clk(clk), .rst_n(rst_n), .act_set_i(act_set_i), .act_clr_i(act_clr_i),
        .iss_n_i(iss_n_i), .flush_n_i(flush_n_i), .redir_i(redir_i),
        .redir_pc_i(redir_pc_i), .fetch_vld_o(fetch_vld_o),
        .fetch_tid_o(fetch_tid_o), .fetch_pc_o(fetch_pc_o), .idle_o(idle_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void predict();
        int mn = 1000;
        e_vld = 0; e_tid = 0;
        for (int i = 0; i < N; i++)
            if (m_act[i] && m_cnt[i] <= 12 && m_cnt[i] < mn) mn = m_cnt[i];
        for (int k = 0; k < N; k++) begin
            int j = (m_rr + k) % N;
            if (!e_vld && m_act[j] && m_cnt[j] <= 12 && m_cnt[j] == mn) begin
                e_vld = 1; e_tid = j;
            end
        end
    endfunction

    // called at a negedge: compare, drive inputs, advance reference
    task automatic step(input logic [3:0] set, input logic [3:0] clr,
                        input logic [11:0] iss, input logic [23:0] fl,
                        input logic [3:0] rd, input logic [31:0] rpc);
        predict();
        chk("R6 grant valid", fetch_vld_o, e_vld);
        chk("R6 idle flag", idle_o, !e_vld);
        if (e_vld) begin
            chk("R3 R4 R7 granted thread", fetch_tid_o, e_tid);
            chk("R8 fetch pc", fetch_pc_o, m_pc[e_tid]);
        end else begin
            chk("R8 pc without grant", fetch_pc_o, 0);
        end
        act_set_i = set; act_clr_i = clr; iss_n_i = iss; flush_n_i = fl;
        redir_i = rd; redir_pc_i = {4{rpc}};
        for (int t = 0; t < N; t++) begin
            int nc;
            bit g = e_vld && (e_tid == t);
            nc = m_cnt[t] + (g ? 4 : 0) - int'(iss[t*3 +: 3]) - int'(fl[t*6 +: 6]);
            m_cnt[t] = (nc < 0) ? 0 : nc;
            if (rd[t]) m_pc[t] = rpc;
            else if (g) m_pc[t] = m_pc[t] + 32'd16;
            if (clr[t]) m_act[t] = 0;
            else if (set[t]) m_act[t] = 1;
        end
        if (e_vld) m_rr = (e_tid + 1) % N;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < N; t++) begin m_act[t] = 0; m_cnt[t] = 0; m_pc[t] = 0; end
        m_rr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 idle after reset", idle_o, 1);
        chk("R1 no grant after reset", fetch_vld_o, 0);
        chk("R1 pc output after reset", fetch_pc_o, 0);

        // R2 activation: thread 1 only; R10 granted every cycle
        step(4'b0010, 4'b0000, '0, '0, '0, '0);
        chk("R2 eligible next cycle", fetch_vld_o, 1);
        chk("R10 single thread id", fetch_tid_o, 1);
        // four grants fill the partition (0,4,8,12 -> 16)
        for (int c = 0; c < 4; c++) begin
            chk("R10 single thread granted", fetch_vld_o, 1);
            step('0, '0, '0, '0, '0, '0);
        end
        chk("R5 full partition not granted", fetch_vld_o, 0);
        chk("R6 idle when full", idle_o, 1);
        // issue 4 from thread 1 -> count 12, granted again
        step('0, '0, 12'h4 << 3, '0, '0, '0);
        chk("R7 issue frees partition", fetch_vld_o, 1);
        chk("R8 pc after four blocks", fetch_pc_o, 32'd64);
        // R9 redirect while granted
        step('0, '0, 12'h4 << 3, '0, 4'b0010, 32'h0000_8000);
        chk("R9 redirect beats advance", fetch_pc_o, 32'h0000_8000);
        // R5 with others: activate threads 0 and 3
        step(4'b1001, '0, '0, '0, '0, '0);
        step('0, '0, '0, '0, '0, '0);
        // R2 clear beats set
        step(4'b0100, 4'b0100, '0, '0, '0, '0);
        for (int c = 0; c < 6; c++) begin
            if (fetch_vld_o) chk("R2 cleared thread never granted", fetch_tid_o == 2, 0);
            step('0, '0, '0, '0, '0, '0);
        end
        // flush everything
        step('0, '0, '0, {4{6'd20}}, '0, '0);
        step(4'b1111, '0, '0, '0, '0, '0);

        // mixed sweep
        for (int n = 0; n < 6000; n++) begin
            logic [3:0] s, c, rd;
            logic [11:0] is;
            logic [23:0] fl;
            s = '0; c = '0; rd = '0; is = '0; fl = '0;
            for (int t = 0; t < N; t++) begin
                int r = $urandom_range(0, 99);
                int avail = m_cnt[t];
                if (r < 3) s[t] = 1'b1;
                else if (r < 5) c[t] = 1'b1;
                else if (r < 7) s[t] = 1'b1 & (r == 6);
                if (avail > 0) begin
                    int k = $urandom_range(0, (avail < 4) ? avail : 4);
                    if ($urandom_range(0, 3) != 0) is[t*3 +: 3] = 3'(k);
                    avail -= int'(is[t*3 +: 3]);
                    if ($urandom_range(0, 39) == 0) fl[t*6 +: 6] = 6'(avail);
                end
                if ($urandom_range(0, 29) == 0) rd[t] = 1'b1;
            end
            if ((n / 1000) % 2 == 1) c = '0;
            step(s, c, is, fl, rd, $urandom & 32'hFFFF_FFF0);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule